// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bus Monitor

This block listens without driving to a single-wire, idle-high serial data line on which each bit is a low pulse whose length encodes its value. It counts, in clock cycles, how long the line stays low between a falling edge and the next rising edge. It then sorts each pulse into one of three classes: a short pulse is a 1 bit, a medium pulse is a 0 bit, and a very long pulse is a break. The time windows are given in microseconds and turned into cycle counts at elaboration from a clock-frequency parameter. The frame assembler gathers accepted bits into a transaction: a 7-bit address, then a direction bit, then a data byte. It reports each complete transaction with a one-cycle strobe.

The monitor has two state machines. The pulse timer has the states PT_IDLE and PT_LOW. It moves from PT_IDLE to PT_LOW on a falling edge. It moves from PT_LOW back to PT_IDLE on a rising edge, and at that point it hands over the measured width. The frame assembler has the states FR_ADDR, FR_DIR and FR_DATA:
- FR_ADDR moves to FR_DIR after the last address bit.
- FR_DIR moves to FR_DATA after the direction bit.
- FR_DATA moves back to FR_ADDR after the last data bit, and the transaction is reported.
- A break returns the assembler from any state to FR_ADDR.

The line input must already be synchronous to `clk`. The block does not check bus turnaround.

Top module: `swire_pulse_monitor`

## Requirements
- R1: A pulse width W is the number of rising clock edges at which `line_in` is sampled low, counted from the first low sample after a high sample. With BRK = floor(CLK_HZ*190/1e6), a pulse with W > BRK is a break, reported as `bit_cls` = 2'b10.
- R2: A pulse with floor(CLK_HZ*86/1e6) <= W <= floor(CLK_HZ*145/1e6) is a 0 bit, reported as `bit_cls` = 2'b00.
- R3: A pulse with floor(CLK_HZ*17/1e6) <= W <= floor(CLK_HZ*50/1e6) is a 1 bit, reported as `bit_cls` = 2'b01.
- R4: A pulse that matches no window produces no `bit_stb`. It leaves the partly received frame unchanged.
- R5: The first seven accepted bits of a frame form `txn_addr`, least-significant bit first.
- R6: The eighth accepted bit is reported on `txn_write`, where 1 means write and 0 means read.
- R7: The next eight bits form `txn_data`, least-significant bit first. When the 16th bit is accepted, `txn_valid` is high for exactly one cycle, and the following bit starts a new address.
- R8: A break at any point discards the partial frame, and the next bit is address bit 0.
- R9: `bit_stb` is high for one cycle, at the second rising edge after the first high sample that ends a pulse. When `txn_valid` fires, it fires in that same cycle.
- R10: Synchronous active-high `rst` clears all outputs and the partial frame. A pulse that is already low when reset releases is not reported.
- R11: The width counter saturates just above BRK, so a pulse far longer than BRK is still reported as a break and never wraps into a bit window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Synchronised bus line, idle high |
| bit_stb | output | 1 | One-cycle strobe per classified pulse |
| bit_cls | output | 2 | Class: 00 zero, 01 one, 10 break |
| txn_valid | output | 1 | One-cycle strobe for a completed transaction |
| txn_addr | output | ADDR_W | Transaction address |
| txn_write | output | 1 | Direction, 1 = write |
| txn_data | output | DATA_W | Transaction data byte |

## Verification
The properties assume that `line_in` changes only between clock edges and that each low pulse is surrounded by high samples. Under those assumptions, two classified pulses can never produce strobes in adjacent cycles. The properties also assume that reset is held for at least one edge before the line is observed. The stimulus changes the line only at falling clock edges and leaves several high cycles after every pulse. The only pulse that reset interrupts is one the monitor must then ignore.

// File: rtl/swire_mon_pkg.sv
package swire_mon_pkg;

    typedef enum logic [1:0] {
        CLS_ZERO  = 2'b00,
        CLS_ONE   = 2'b01,
        CLS_BREAK = 2'b10,
        CLS_NONE  = 2'b11
    } pulse_cls_t;

    typedef enum logic {
        PT_IDLE = 1'b0,
        PT_LOW  = 1'b1
    } timer_st_t;

    typedef enum logic [1:0] {
        FR_ADDR = 2'b00,
        FR_DIR  = 2'b01,
        FR_DATA = 2'b10
    } frame_st_t;

    // microseconds to clock cycles, truncating
    function automatic int unsigned us_to_cycles(input longint unsigned hz,
                                                 input longint unsigned us);
        longint unsigned prod;
        prod = (hz * us) / 64'd1_000_000;
        return prod[31:0];
    endfunction

endpackage

// File: rtl/swire_pulse_timer.sv
module swire_pulse_timer
    import swire_mon_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int SAT_VAL = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    output logic             pulse_done,
    output logic [CNT_W-1:0] pulse_width
);
    localparam logic [CNT_W-1:0] SAT_LIM = CNT_W'(SAT_VAL);
    localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

    timer_st_t        st;
    logic             line_q;
    logic [CNT_W-1:0] cnt;
    logic             fall;
    logic             rise_end;

    // line_q resets low so a line already low at release shows no fall
    assign fall     = line_q & ~line_in;
    assign rise_end = (st == PT_LOW) & line_in;

    // state register and width counter
    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= PT_IDLE;
            line_q <= 1'b0;
            cnt    <= '0;
        end else begin
            line_q <= line_in;
            unique case (st)
                PT_IDLE: begin
                    if (fall) begin
                        st  <= PT_LOW;
                        cnt <= ONE_CNT;
                    end
                end
                PT_LOW: begin
                    if (line_in) begin
                        st <= PT_IDLE;
                    end else if (cnt != SAT_LIM) begin
                        cnt <= cnt + ONE_CNT;
                    end
                end
                default: st <= PT_IDLE;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_done  <= 1'b0;
            pulse_width <= '0;
        end else begin
            pulse_done <= rise_end;
            if (rise_end) begin
                pulse_width <= cnt;
            end
        end
    end

endmodule

// File: rtl/swire_pulse_classifier.sv
module swire_pulse_classifier
    import swire_mon_pkg::*;
#(
    parameter int          CNT_W    = 16,
    parameter int unsigned BRK_CYC  = 380,
    parameter int unsigned ZMIN_CYC = 172,
    parameter int unsigned ZMAX_CYC = 290,
    parameter int unsigned OMIN_CYC = 34,
    parameter int unsigned OMAX_CYC = 100
) (
    input  logic [CNT_W-1:0] width,
    output pulse_cls_t       cls
);
    logic [31:0] w32;

    assign w32 = 32'(width);

    always_comb begin
        if (w32 > BRK_CYC) begin
            cls = CLS_BREAK;
        end else if (w32 >= ZMIN_CYC && w32 <= ZMAX_CYC) begin
            cls = CLS_ZERO;
        end else if (w32 >= OMIN_CYC && w32 <= OMAX_CYC) begin
            cls = CLS_ONE;
        end else begin
            cls = CLS_NONE;
        end
    end

endmodule

// File: rtl/swire_frame_fsm.sv
module swire_frame_fsm
    import swire_mon_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pulse_done,
    input  pulse_cls_t        cls,
    output logic              bit_stb,
    output logic [1:0]        bit_cls,
    output logic              txn_valid,
    output logic [ADDR_W-1:0] txn_addr,
    output logic              txn_write,
    output logic [DATA_W-1:0] txn_data
);
    localparam int IDX_W = $clog2((ADDR_W > DATA_W) ? ADDR_W : DATA_W);
    localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(ADDR_W - 1);
    localparam logic [IDX_W-1:0] DATA_LAST = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0] IDX_ONE   = IDX_W'(1);

    frame_st_t         st;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] addr_sr;
    logic [DATA_W-1:0] data_sr;
    logic              dir_q;
    logic              is_bit;
    logic              bval;
    logic              last_bit;

    assign is_bit   = pulse_done & ((cls == CLS_ZERO) | (cls == CLS_ONE));
    assign bval     = (cls == CLS_ONE);
    assign last_bit = is_bit & (st == FR_DATA) & (idx == DATA_LAST);

    // state register and partial frame
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= FR_ADDR;
            idx     <= '0;
            addr_sr <= '0;
            data_sr <= '0;
            dir_q   <= 1'b0;
        end else if (pulse_done && cls == CLS_BREAK) begin
            st      <= FR_ADDR;
            idx     <= '0;
            addr_sr <= '0;
            data_sr <= '0;
            dir_q   <= 1'b0;
        end else if (is_bit) begin
            unique case (st)
                FR_ADDR: begin
                    addr_sr <= {bval, addr_sr[ADDR_W-1:1]};
                    if (idx == ADDR_LAST) begin
                        st  <= FR_DIR;
                        idx <= '0;
                    end else begin
                        idx <= idx + IDX_ONE;
                    end
                end
                FR_DIR: begin
                    dir_q <= bval;
                    st    <= FR_DATA;
                    idx   <= '0;
                end
                FR_DATA: begin
                    if (idx == DATA_LAST) begin
                        st      <= FR_ADDR;
                        idx     <= '0;
                        data_sr <= '0;
                    end else begin
                        data_sr <= {bval, data_sr[DATA_W-1:1]};
                        idx     <= idx + IDX_ONE;
                    end
                end
                default: begin
                    st  <= FR_ADDR;
                    idx <= '0;
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_stb   <= 1'b0;
            bit_cls   <= 2'b00;
            txn_valid <= 1'b0;
            txn_addr  <= '0;
            txn_write <= 1'b0;
            txn_data  <= '0;
        end else begin
            bit_stb   <= pulse_done & (cls != CLS_NONE);
            txn_valid <= last_bit;
            if (pulse_done) begin
                bit_cls <= cls;
            end
            if (last_bit) begin
                txn_addr  <= addr_sr;
                txn_write <= dir_q;
                txn_data  <= {bval, data_sr[DATA_W-1:1]};
            end
        end
    end

endmodule

// File: rtl/swire_pulse_monitor.sv
module swire_pulse_monitor
    import swire_mon_pkg::*;
#(
    parameter longint unsigned CLK_HZ      = 200_000_000,
    parameter int unsigned     BRK_US      = 190,
    parameter int unsigned     ZERO_MIN_US = 86,
    parameter int unsigned     ZERO_MAX_US = 145,
    parameter int unsigned     ONE_MIN_US  = 17,
    parameter int unsigned     ONE_MAX_US  = 50,
    parameter int              ADDR_W      = 7,
    parameter int              DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_in,
    output logic              bit_stb,
    output logic [1:0]        bit_cls,
    output logic              txn_valid,
    output logic [ADDR_W-1:0] txn_addr,
    output logic              txn_write,
    output logic [DATA_W-1:0] txn_data
);
    localparam int unsigned BRK_CYC  = us_to_cycles(CLK_HZ, 64'(BRK_US));
    localparam int unsigned ZMIN_CYC = us_to_cycles(CLK_HZ, 64'(ZERO_MIN_US));
    localparam int unsigned ZMAX_CYC = us_to_cycles(CLK_HZ, 64'(ZERO_MAX_US));
    localparam int unsigned OMIN_CYC = us_to_cycles(CLK_HZ, 64'(ONE_MIN_US));
    localparam int unsigned OMAX_CYC = us_to_cycles(CLK_HZ, 64'(ONE_MAX_US));
    localparam int          SAT_VAL  = int'(BRK_CYC) + 1;
    localparam int          CNT_W    = $clog2(SAT_VAL + 1);

    logic             pulse_done;
    logic [CNT_W-1:0] pulse_width;
    pulse_cls_t       cls;

    swire_pulse_timer #(
        .CNT_W  (CNT_W),
        .SAT_VAL(SAT_VAL)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .line_in    (line_in),
        .pulse_done (pulse_done),
        .pulse_width(pulse_width)
    );

    swire_pulse_classifier #(
        .CNT_W   (CNT_W),
        .BRK_CYC (BRK_CYC),
        .ZMIN_CYC(ZMIN_CYC),
        .ZMAX_CYC(ZMAX_CYC),
        .OMIN_CYC(OMIN_CYC),
        .OMAX_CYC(OMAX_CYC)
    ) u_cls (
        .width(pulse_width),
        .cls  (cls)
    );

    swire_frame_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_frame (
        .clk       (clk),
        .rst       (rst),
        .pulse_done(pulse_done),
        .cls       (cls),
        .bit_stb   (bit_stb),
        .bit_cls   (bit_cls),
        .txn_valid (txn_valid),
        .txn_addr  (txn_addr),
        .txn_write (txn_write),
        .txn_data  (txn_data)
    );

endmodule

// File: rtl/swire_mon_checks.sv
module swire_mon_checks (
    input logic       clk,
    input logic       rst,
    input logic       bit_stb,
    input logic [1:0] bit_cls,
    input logic       txn_valid
);
    // R9: strobes never occupy two adjacent cycles
    a_r9_bit_single: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);

    // R7: transaction strobe lasts one cycle
    a_r7_txn_single: assert property (@(posedge clk) disable iff (rst)
        txn_valid |=> !txn_valid);

    // R7, R8, R9: a transaction coincides with a data-bit strobe, never a break
    a_r7_txn_on_bit: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (bit_stb && (bit_cls == 2'b00 || bit_cls == 2'b01)));

    // R4: a reported class is always a legal one
    a_r4_class_legal: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> (bit_cls != 2'b11));

    // R10: nothing is reported in the first cycle after reset
    a_r10_quiet_release: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!bit_stb && !txn_valid));

endmodule

bind swire_pulse_monitor swire_mon_checks u_chk (
    .clk      (clk),
    .rst      (rst),
    .bit_stb  (bit_stb),
    .bit_cls  (bit_cls),
    .txn_valid(txn_valid)
);

// File: tb/sim_swire_pulse_monitor.sv
`timescale 1ns/1ps
module sim_swire_pulse_monitor;
    localparam longint unsigned HZ = 2_000_000;
    localparam int BRK  = int'((HZ * 190) / 1_000_000);
    localparam int ZMIN = int'((HZ * 86) / 1_000_000);
    localparam int ZMAX = int'((HZ * 145) / 1_000_000);
    localparam int OMIN = int'((HZ * 17) / 1_000_000);
    localparam int OMAX = int'((HZ * 50) / 1_000_000);
    localparam int W_ONE  = 60;
    localparam int W_ZERO = 230;
    localparam int W_BAD  = 140;
    localparam int W_BRK  = 450;
    localparam int GAP    = 8;

    localparam int NV = 12;
    localparam int VW [NV] = '{1, OMIN-1, OMIN, OMAX, OMAX+1, ZMIN-1,
                               ZMIN, ZMAX, ZMAX+1, BRK, BRK+1, 600};
    // {strobe expected, class}
    localparam logic [2:0] VX [NV] = '{3'b000, 3'b000, 3'b101, 3'b101,
                                       3'b000, 3'b000, 3'b100, 3'b100,
                                       3'b000, 3'b000, 3'b110, 3'b110};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_in = 1'b1;
    logic       bit_stb;
    logic [1:0] bit_cls;
    logic       txn_valid;
    logic [6:0] txn_addr;
    logic       txn_write;
    logic [7:0] txn_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    swire_pulse_monitor #(.CLK_HZ(HZ)) u0 (
        .clk(clk), .rst(rst), .line_in(line_in),
        .bit_stb(bit_stb), .bit_cls(bit_cls), .txn_valid(txn_valid),
        .txn_addr(txn_addr), .txn_write(txn_write), .txn_data(txn_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // starts and ends at a falling clock edge
    task automatic pulse(input int w, output logic stb, output logic [1:0] cls,
                         output logic tv, output logic tv_next);
        line_in = 1'b0;
        repeat (w) @(negedge clk);
        line_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        stb = bit_stb; cls = bit_cls; tv = txn_valid;
        @(negedge clk);
        tv_next = txn_valid;
        repeat (GAP) @(negedge clk);
    endtask

    // sends n bits of v, LSB first; reports txn on last bit, and any earlier
    task automatic send_bits(input logic [15:0] v, input int n,
                             output logic early, output logic tv_last,
                             output logic tv_after);
        logic s, t, tn;
        logic [1:0] c;
        early = 1'b0; tv_last = 1'b0; tv_after = 1'b0;
        for (int i = 0; i < n; i++) begin
            pulse(v[i] ? W_ONE : W_ZERO, s, c, t, tn);
            if (i < n - 1) early = early | t;
            else begin tv_last = t; tv_after = tn; end
        end
    endtask

    function automatic logic [15:0] frame(input logic [6:0] a, input logic w,
                                          input logic [7:0] d);
        return {d, w, a};
    endfunction

    initial begin
        logic s, t, tn, e, tl, ta;
        logic [1:0] c;
        repeat (4) @(negedge clk);
        // R10: reset state
        check(bit_stb == 0 && txn_valid == 0, "R10 reset strobes", {bit_stb, txn_valid}, 0);
        check(txn_addr == 0 && txn_data == 0 && txn_write == 0, "R10 reset fields",
              {txn_addr, txn_write, txn_data}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 R2 R3 R4 R11: width table; breaks between entries clear any frame
        for (int k = 0; k < NV; k++) begin
            pulse(VW[k], s, c, t, tn);
            check(s == VX[k][2], "R1/R2/R3/R4/R11 strobe", s, VX[k][2]);
            if (VX[k][2])
                check(c == VX[k][1:0], "R1/R2/R3/R11 class", c, VX[k][1:0]);
        end
        pulse(W_BRK, s, c, t, tn);

        // R5 R6 R7 R9: write frame
        send_bits(frame(7'h35, 1'b1, 8'hC3), 16, e, tl, ta);
        check(!e, "R7 no early txn", e, 0);
        check(tl, "R9 txn with last bit", tl, 1);
        check(!ta, "R7 txn one cycle", ta, 0);
        check(txn_addr == 7'h35, "R5 address", txn_addr, 7'h35);
        check(txn_write == 1'b1, "R6 write", txn_write, 1);
        check(txn_data == 8'hC3, "R7 data", txn_data, 8'hC3);

        // R6 R7: read frame straight after (counter returned to address)
        send_bits(frame(7'h0A, 1'b0, 8'h81), 16, e, tl, ta);
        check(tl && !e, "R7 back-to-back txn", {e, tl}, 1);
        check(txn_addr == 7'h0A && txn_write == 1'b0 && txn_data == 8'h81,
              "R6 read frame", {txn_addr, txn_write, txn_data}, {7'h0A, 1'b0, 8'h81});

        // R8: break after five address bits
        send_bits(16'h001F, 5, e, tl, ta);
        pulse(W_BRK, s, c, t, tn);
        check(s && c == 2'b10 && !t, "R8 break reported", {s, c, t}, 3'b110);
        send_bits(frame(7'h52, 1'b1, 8'h3C), 16, e, tl, ta);
        check(tl && !e, "R8 frame after break", {e, tl}, 1);
        check(txn_addr == 7'h52 && txn_data == 8'h3C, "R8 fields",
              {txn_addr, txn_data}, {7'h52, 8'h3C});

        // R4: invalid pulse inside a frame does not advance it
        begin
            logic [15:0] f;
            f = frame(7'h61, 1'b0, 8'h5A);
            send_bits(f, 3, e, tl, ta);
            pulse(W_BAD, s, c, t, tn);
            check(!s, "R4 invalid ignored", s, 0);
            send_bits(f >> 3, 13, e, tl, ta);
            check(tl && !e, "R4 frame completes", {e, tl}, 1);
            check(txn_addr == 7'h61 && txn_write == 0 && txn_data == 8'h5A,
                  "R4 fields", {txn_addr, txn_write, txn_data}, {7'h61, 1'b0, 8'h5A});
        end

        // R10: pulse in progress across reset is not reported
        line_in = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        line_in = 1'b1;
        @(negedge clk); @(negedge clk);
        check(!bit_stb, "R10 no report of pre-reset pulse", bit_stb, 0);
        repeat (GAP) @(negedge clk);

        // R10: reset discards partial frame
        send_bits(16'h000F, 4, e, tl, ta);
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        send_bits(frame(7'h7F, 1'b1, 8'hFE), 16, e, tl, ta);
        check(tl && !e, "R10 frame after reset", {e, tl}, 1);
        check(txn_addr == 7'h7F && txn_data == 8'hFE, "R10 fields",
              {txn_addr, txn_data}, {7'h7F, 8'hFE});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule